// File: doc/BRIEF.md
# Timekeeping Register Window with Frozen User Copy

This block places eight clock-and-calendar registers at the highest eight byte addresses of a byte-wide memory space and passes every other address to an external RAM port. The host drives a static-memory style bus with active-low chip select, output enable and write enable. Between that bus and a separate counter block, the window keeps a user-visible copy of the time. The host reads and writes this copy. The counter block stays off the bus and only supplies its current value and a tick.

Two control bits in the century register decide how the copy moves. With both bits clear, the copy takes the counter's value on every tick. The hold-for-read bit freezes the copy so the host can read a consistent snapshot while counting continues underneath. The hold-for-write bit also freezes the copy, so the host can load new values. Clearing it sends the whole copy to the counter block in a single load strobe.

Top module: `clkreg_window`

## Requirements
- R1: Addresses whose upper bits are all ones select one of eight registers by their low three bits: offset 0 century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Every other address goes to the RAM port, with `ram_addr` equal to `addr`, `ram_wdata` equal to `wdata`, and `ram_we` high for a write.
- R2: `dq_drive` is high only when `pwr_ok` is 1, `cs_n` is 0, `oe_n` is 0 and `we_n` is 1. In that state `rdata` carries the selected register or `ram_rdata`. In every other state `dq_drive` is 0 and `rdata` is 0.
- R3: A write takes effect on each clock edge where `pwr_ok` is 1 and both `cs_n` and `we_n` are 0, whatever the level of `oe_n`. The bus is not driven during a write.
- R4: While `pwr_ok` is 0, no register changes through the bus, `ram_we` stays 0 and `dq_drive` stays 0.
- R5: While both hold bits are 0, the user copy takes the counter value on every edge where `cnt_tick` is 1. The new value is readable in the following cycle.
- R6: While the hold-for-read bit (century bit 6) is 1, ticks leave the user copy unchanged.
- R7: While the hold-for-write bit (century bit 7) is 1, ticks leave the user copy unchanged, and host writes land in the copy.
- R8: A century write with bit 7 = 0, made while the hold-for-write bit is 1, raises `ld_strobe` for exactly the next cycle. In that cycle `ld_time` holds the user copy, byte k at bits 8k+7..8k, with century bits 7:6 = 0. No other write raises `ld_strobe`.
- R9: A tick that arrives in the cycle where `ld_strobe` is high does not change the user copy.
- R10: After the hold-for-read bit is cleared with the hold-for-write bit at 0, the first tick refreshes all eight registers in the same edge. Until that tick they keep their frozen values.
- R11: Bits that are not used read back as 0, whatever is written to them. The stored bits are: century 5:0 plus the hold bits 7:6, seconds 7:0 (bit 7 is the oscillator stop), minutes 6:0, hours 5:0, day 6 (frequency test) and 2:0, date 5:0, month 4:0, year 7:0.
- R12: Day bit 7 always reads the level of `batt_ok`. Writes to it are ignored.
- R13: After reset, both hold bits are 0, every stored bit is 0 and `ld_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply in tolerance; 0 blocks all access |
| batt_ok | input | 1 | Backup battery good, shown in day bit 7 |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| dq_drive | output | 1 | Host data bus driven (tri-state control) |
| ram_we | output | 1 | Write strobe to the RAM |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| cnt_tick | input | 1 | Counter advanced this cycle |
| cnt_time | input | 64 | Counter value, byte k at register offset k |
| ld_strobe | output | 1 | One-cycle load request to the counter |
| ld_time | output | 64 | Values to load, byte k at register offset k |

## Verification
Two events can fall in the same cycle: the load strobe that follows a clear of the hold-for-write bit, and a counter tick. The bench provokes this by raising `cnt_tick` with a fresh counter value in exactly the cycle where `ld_strobe` is high. It then reads all eight registers back and expects every one to hold the loaded values rather than the tick's. A second pairing, clearing the hold-for-read bit followed by a tick, is checked the same way: each register is read before and after the first tick to show that all eight change together.

// File: rtl/clkreg_pkg.sv
// Shared constants and field masks for the clock register window.
// Assumes eight registers of one byte each; offset 0 is century, 4 is day.
package clkreg_pkg;
    localparam int DATA_W   = 8;
    localparam int NREG     = 8;
    localparam int IDX_W    = $clog2(NREG);
    localparam int IDX_CENT = 0;
    localparam int IDX_DAY  = 4;

    // Bits of each register held in the user copy (hold bits kept separately)
    function automatic logic [DATA_W-1:0] keep_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    keep_mask = 8'h3F;
            3'd1:    keep_mask = 8'hFF;
            3'd2:    keep_mask = 8'h7F;
            3'd3:    keep_mask = 8'h3F;
            3'd4:    keep_mask = 8'h47;
            3'd5:    keep_mask = 8'h3F;
            3'd6:    keep_mask = 8'h1F;
            default: keep_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/clkreg_decode.sv
// Bus cycle decoder: classifies the bus state into read and write and finds
// whether the address falls in the register window.
// Assumes the register window is the top NREG addresses of the space.
module clkreg_decode
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              pwr_ok,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              reg_hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI_W = ADDR_W - IDX_W;

    // Access qualification and window decode
    always_comb begin
        wr_en   = pwr_ok && !cs_n && !we_n;
        rd_en   = pwr_ok && !cs_n && !oe_n && we_n;
        reg_hit = (addr[ADDR_W-1:IDX_W] == {HI_W{1'b1}});
        idx     = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/clkreg_shadow.sv
// User copy of the eight time registers plus the hold-for-read and
// hold-for-write bits. Refreshes from the counter on ticks while no hold bit
// is set, and issues one load strobe when hold-for-write is cleared.
// Assumes a host write to a byte wins over a refresh in the same cycle.
module clkreg_shadow
    import clkreg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   cnt_tick,
    input  logic [NREG*DATA_W-1:0] cnt_time,
    output logic [NREG*DATA_W-1:0] copy_flat,
    output logic                   w_hold,
    output logic                   r_hold,
    output logic                   ld_strobe,
    output logic [NREG*DATA_W-1:0] ld_time
);
    logic refresh;
    logic cent_wr;

    // Refresh only when neither hold is set and no load is in flight
    always_comb begin
        cent_wr = reg_wr && (idx == IDX_W'(IDX_CENT));
        refresh = cnt_tick && !w_hold && !r_hold && !ld_strobe;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_byte
        logic [DATA_W-1:0] q;
        // One byte of the user copy: host write first, then counter refresh
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (reg_wr && (idx == IDX_W'(k)))
                q <= wdata & keep_mask(IDX_W'(k));
            else if (refresh)
                q <= cnt_time[k*DATA_W +: DATA_W] & keep_mask(IDX_W'(k));
        end
        assign copy_flat[k*DATA_W +: DATA_W] = q;
    end

    // Hold bits and the load strobe on a falling hold-for-write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_hold    <= 1'b0;
            r_hold    <= 1'b0;
            ld_strobe <= 1'b0;
        end else begin
            ld_strobe <= cent_wr && w_hold && !wdata[7];
            if (cent_wr) begin
                w_hold <= wdata[7];
                r_hold <= wdata[6];
            end
        end
    end

    assign ld_time = copy_flat;

    // R8: the strobe never lasts two cycles
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |=> !ld_strobe);

    // R8: a strobe follows a cycle with hold-for-write set and leaves it clear
    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |-> ($past(w_hold) && !w_hold));

    // R6: with hold-for-read set and no host write the copy stays put
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_hold && !reg_wr) |=> $stable(copy_flat));

    // R9: a tick during the strobe cycle leaves the copy alone
    p_strobe_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && cnt_tick && !reg_wr) |=> $stable(copy_flat));
endmodule

// File: rtl/clkreg_rdmux.sv
// Read data selector: composes register bytes with hold and battery bits,
// or passes RAM data, and returns zero when the bus is not being read.
// Assumes purely combinational RAM read data.
module clkreg_rdmux
    import clkreg_pkg::*;
(
    input  logic [NREG*DATA_W-1:0] copy_flat,
    input  logic                   w_hold,
    input  logic                   r_hold,
    input  logic                   batt_ok,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   reg_hit,
    input  logic                   rd_en,
    input  logic [DATA_W-1:0]      ram_rdata,
    output logic [DATA_W-1:0]      rdata
);
    logic [DATA_W-1:0] reg_byte;

    // Build the register byte and pick the source
    always_comb begin
        reg_byte = copy_flat[idx*DATA_W +: DATA_W];
        if (idx == IDX_W'(IDX_CENT))
            reg_byte[7:6] = {w_hold, r_hold};
        if (idx == IDX_W'(IDX_DAY))
            reg_byte[7] = batt_ok;
        if (!rd_en)
            rdata = '0;
        else if (reg_hit)
            rdata = reg_byte;
        else
            rdata = ram_rdata;
    end
endmodule

// File: rtl/clkreg_window.sv
// Clock register window: maps the eight time registers onto the top of a
// byte-wide address space, passes other addresses to a RAM port and keeps a
// user copy between the host and the counter block.
// Assumes the counter block loads ld_time on ld_strobe with priority over
// its own tick.
module clkreg_window
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_ok,
    input  logic                   batt_ok,
    input  logic                   cs_n,
    input  logic                   oe_n,
    input  logic                   we_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   dq_drive,
    output logic                   ram_we,
    output logic [ADDR_W-1:0]      ram_addr,
    output logic [DATA_W-1:0]      ram_wdata,
    input  logic [DATA_W-1:0]      ram_rdata,
    input  logic                   cnt_tick,
    input  logic [NREG*DATA_W-1:0] cnt_time,
    output logic                   ld_strobe,
    output logic [NREG*DATA_W-1:0] ld_time
);
    logic                   rd_en;
    logic                   wr_en;
    logic                   reg_hit;
    logic [IDX_W-1:0]       idx;
    logic                   reg_wr;
    logic [NREG*DATA_W-1:0] copy_flat;
    logic                   w_hold;
    logic                   r_hold;

    clkreg_decode #(.ADDR_W(ADDR_W)) i_decode (
        .pwr_ok  (pwr_ok),
        .cs_n    (cs_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .reg_hit (reg_hit),
        .idx     (idx)
    );

    // Split writes between the register copy and the RAM port
    always_comb begin
        reg_wr    = wr_en && reg_hit;
        ram_we    = wr_en && !reg_hit;
        ram_addr  = addr;
        ram_wdata = wdata;
        dq_drive  = rd_en;
    end

    clkreg_shadow i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .idx       (idx),
        .wdata     (wdata),
        .cnt_tick  (cnt_tick),
        .cnt_time  (cnt_time),
        .copy_flat (copy_flat),
        .w_hold    (w_hold),
        .r_hold    (r_hold),
        .ld_strobe (ld_strobe),
        .ld_time   (ld_time)
    );

    clkreg_rdmux i_rdmux (
        .copy_flat (copy_flat),
        .w_hold    (w_hold),
        .r_hold    (r_hold),
        .batt_ok   (batt_ok),
        .idx       (idx),
        .reg_hit   (reg_hit),
        .rd_en     (rd_en),
        .ram_rdata (ram_rdata),
        .rdata     (rdata)
    );

    // R4: nothing reaches the bus or the RAM while power is bad
    p_quiet_when_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (!dq_drive && !ram_we));

    // R3: the bus is never driven during a write
    p_no_drive_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dq_drive);

    // R1: a write goes to the RAM or to the registers, never both
    p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && reg_wr));
endmodule

// File: tb/test_clkreg_window.sv
module test_clkreg_window;
    localparam int AW = 15;
    localparam logic [AW-1:0] BASE = 15'h7FF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_ok = 1'b1;
    logic        batt_ok = 1'b1;
    logic        cs_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        dq_drive;
    logic        ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic        cnt_tick = 1'b0;
    logic [63:0] cnt_time = '0;
    logic        ld_strobe;
    logic [63:0] ld_time;

    int checks = 0;
    int errs = 0;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] m [8];
    logic       mw = 1'b0;
    logic       mr = 1'b0;

    always #10 clk = ~clk;

    clkreg_window #(.ADDR_W(AW)) i_clkreg_window (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .batt_ok(batt_ok),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dq_drive(dq_drive), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .cnt_tick(cnt_tick), .cnt_time(cnt_time),
        .ld_strobe(ld_strobe), .ld_time(ld_time)
    );

    assign ram_rdata = mem[ram_addr[7:0]];
    always @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;

    function automatic logic [7:0] bmask(input int k);
        case (k)
            0: return 8'h3F; 1: return 8'hFF; 2: return 8'h7F; 3: return 8'h3F;
            4: return 8'h47; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_reg(input int k);
        logic [7:0] v;
        v = m[k];
        if (k == 0) v[7:6] = {mw, mr};
        if (k == 4) v[7] = batt_ok;
        return v;
    endfunction

    function automatic logic [63:0] exp_ld();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = m[k];
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic reg_wr(input int k, input logic [7:0] d);
        bus_wr(BASE + AW'(k), d);
        if (pwr_ok) begin
            if (k == 0) begin mw = d[7]; mr = d[6]; end
            m[k] = d & bmask(k);
        end
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        chk(req, {63'd0, dq_drive}, 64'd1);
        chk(req, {56'd0, rdata}, {56'd0, exp});
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_all(input string req);
        for (int k = 0; k < 8; k++) bus_rd(BASE + AW'(k), exp_reg(k), req);
    endtask

    task automatic do_tick(input logic [63:0] t);
        @(negedge clk);
        cnt_time = t; cnt_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
        if (!mw && !mr)
            for (int k = 0; k < 8; k++) m[k] = t[k*8 +: 8] & bmask(k);
    endtask

    initial begin
        #(20 * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [63:0] t;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        for (int k = 0; k < 8; k++) m[k] = '0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R13: reset state
        chk("R13", {63'd0, ld_strobe}, 64'd0);
        rd_all("R13");

        // R11 / R12: masks and battery flag; sets both holds
        for (int k = 0; k < 8; k++) reg_wr(k, 8'hFF);
        rd_all("R11");
        batt_ok = 1'b0;
        bus_rd(BASE + 15'd4, 8'h47, "R12");
        batt_ok = 1'b1;
        bus_rd(BASE + 15'd4, 8'hC7, "R12");

        // R8: clear hold-for-write, keep hold-for-read
        reg_wr(0, 8'h40);
        chk("R8 strobe", {63'd0, ld_strobe}, 64'd1);
        chk("R8 ld_time", ld_time, exp_ld());
        @(negedge clk);
        chk("R8 single", {63'd0, ld_strobe}, 64'd0);

        // R6: ticks ignored while hold-for-read set
        do_tick({8{8'h11}});
        rd_all("R6");

        // R10: clear hold-for-read, no strobe, values stay until first tick
        reg_wr(0, 8'h00);
        chk("R8 no strobe", {63'd0, ld_strobe}, 64'd0);
        bus_rd(BASE + 15'd1, 8'hFF, "R10 frozen");
        do_tick(64'h23_11_08_05_14_30_45_20);
        rd_all("R10");

        // R5: follow mode
        do_tick(64'h24_12_31_07_23_59_59_21);
        rd_all("R5");

        // R7: hold-for-write, host loads, ticks ignored
        reg_wr(0, 8'h80);
        do_tick({8{8'h22}});
        reg_wr(1, 8'h07); reg_wr(2, 8'h15); reg_wr(3, 8'h09);
        reg_wr(5, 8'h28); reg_wr(6, 8'h02); reg_wr(7, 8'h99);
        rd_all("R7");

        // R9: strobe and tick in the same cycle
        reg_wr(0, 8'h05);
        cnt_time = {8{8'h33}}; cnt_tick = 1'b1;
        chk("R9 strobe", {63'd0, ld_strobe}, 64'd1);
        chk("R9 ld_time", ld_time, exp_ld());
        @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
        rd_all("R9");

        // R2: no drive with oe_n high
        @(negedge clk);
        addr = BASE; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        #2;
        chk("R2", {55'd0, dq_drive, rdata}, 64'd0);
        cs_n = 1'b1;

        // R3: write with oe_n low still lands, no drive
        @(negedge clk);
        addr = BASE + 15'd7; wdata = 8'h42; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        #2;
        chk("R3", {63'd0, dq_drive}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        m[7] = 8'h42;
        bus_rd(BASE + 15'd7, 8'h42, "R3");

        // R4: power fail blocks everything
        pwr_ok = 1'b0;
        @(negedge clk);
        addr = 15'h0010; wdata = 8'hAA; cs_n = 1'b0; we_n = 1'b0;
        #2;
        chk("R4 ram_we", {63'd0, ram_we}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b0;
        #2;
        chk("R4 drive", {63'd0, dq_drive}, 64'd0);
        cs_n = 1'b1; oe_n = 1'b1;
        reg_wr(3, 8'h01);
        pwr_ok = 1'b1;
        bus_rd(15'h0010, 8'h00, "R4");
        bus_rd(BASE + 15'd3, exp_reg(3), "R4");

        // R1: address just below the window goes to RAM
        bus_wr(15'h7FF7, 8'h5A);
        exp_mem[8'hF7] = 8'h5A;
        bus_rd(15'h7FF7, 8'h5A, "R1");
        rd_all("R1");

        // Random mix: follow mode ticks and RAM traffic
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [AW-1:0] a;
            logic [7:0] d;
            op = int'($urandom % 4);
            a = AW'($urandom % 32'h7FF0);
            d = 8'($urandom);
            case (op)
                0: begin
                    t = {$urandom, $urandom};
                    do_tick(t);
                end
                1: begin bus_wr(a, d); exp_mem[a[7:0]] = d; end
                2: bus_rd(a, exp_mem[a[7:0]], "R1 ram");
                default: begin
                    int k;
                    k = int'($urandom % 8);
                    bus_rd(BASE + AW'(k), exp_reg(k), "R5 rand");
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule